// File: doc/BRIEF.md
# Masked XON/XOFF Flow-Control Character Recognizer

This block sits after the character assembler of an asynchronous serial receiver. For each received character it checks whether the character is an in-band flow-control code. A character arrives as one cycle of `rx_valid` with its data and two flags: framing good and parity good. The block compares the character with two programmable codes, one that resumes the peer and one that pauses it. Each code has a per-bit don't-care mask. Only the bits covered by the configured character length take part in the comparison.

A valid pause code sets a transmit-hold flag. The flag gates the start of new local transmit characters. A character already being sent is not affected, because only new starts are gated. A valid resume code clears the flag. Each recognition also gives a one-cycle event pulse, which can raise an interrupt. Every received character is passed on to the receive FIFO write port. The exception is recognized control codes while the discard option is set.

The flag is held by a two-state machine. Its states are `FLOW_RUN` (transmission allowed) and `FLOW_STOP` (new starts held off). The transition `RUN->STOP` is taken on a valid pause code. The transition `STOP->RUN` is taken on a valid resume code that is not also a pause code. The self-loops `RUN->RUN` and `STOP->STOP` are taken on anything else.

Top module: `flow_char_detect`

## Requirements
- R1: After reset: `tx_hold`=0, `xon_seen`=0, `xoff_seen`=0 and `fifo_wr`=0. Both mask registers read 0x00, the resume code reads 0x11 and the pause code reads 0x13.
- R2: The register map is: address 0 is the resume code, 1 the pause code, 2 the resume mask and 3 the pause mask. A write with `cfg_we`=1 takes effect at the clock edge. `cfg_rdata` shows the addressed register combinationally.
- R3: `char_len` selects the compared width: 0 compares 5 bits, 1 compares 6, 2 compares 7 and 3 compares 8. Received bits above that width never affect recognition.
- R4: A 1 in a mask bit makes that bit position a don't-care for the code the mask belongs to.
- R5: A character with `rx_frame_ok`=0 is never recognized.
- R6: With `par_en`=1 a character needs `rx_par_ok`=1 to be recognized. With `par_en`=0 the flag `rx_par_ok` is ignored.
- R7: A valid pause code sets `tx_hold` and a valid resume code clears it. The change is visible in the cycle after the `rx_valid` cycle. A repeated code leaves `tx_hold` unchanged.
- R8: A character that matches both codes is taken as a pause code only. `xoff_seen` pulses, `xon_seen` stays 0, and `tx_hold` becomes 1.
- R9: Each recognized character gives exactly one cycle of `xon_seen` or `xoff_seen`, in the cycle after the `rx_valid` cycle.
- R10: In the cycle after each `rx_valid` cycle, `fifo_wr`=1 and `fifo_data` equals `rx_data`. The exception is a recognized control character while `discard_en`=1, which gives `fifo_wr`=0. Unrecognized characters are always forwarded.
- R11: `tx_start_grant` = `tx_start_req` and not `tx_hold`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| char_len | input | 2 | Character length select (5 to 8 bits) |
| par_en | input | 1 | Parity in use |
| discard_en | input | 1 | Drop recognized control characters from FIFO path |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character, LSB aligned |
| rx_frame_ok | input | 1 | Stop bit was correct |
| rx_par_ok | input | 1 | Parity was correct |
| fifo_wr | output | 1 | Receive FIFO write |
| fifo_data | output | 8 | Receive FIFO write data |
| xon_seen | output | 1 | Resume code recognized pulse |
| xoff_seen | output | 1 | Pause code recognized pulse |
| tx_hold | output | 1 | Remote asked for transmission to pause |
| tx_start_req | input | 1 | Transmitter wants to start a character |
| tx_start_grant | output | 1 | Transmitter may start the character |

## Verification
`fifo_wr`, `fifo_data`, both event pulses and `tx_hold` are all registered once. They belong to the cycle directly after the `rx_valid` cycle. `tx_start_grant` and `cfg_rdata` are combinational and are due in the same cycle, after any earlier register write has settled. The bench changes inputs on the falling edge and holds `rx_valid` for exactly one rising edge. It checks the registered results on the next falling edge, then checks again one cycle later that the pulses have dropped.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int unsigned FC_DATA_W  = 8;
    localparam int unsigned FC_LEN_W   = 2;
    localparam int unsigned FC_MIN_LEN = 5;
    localparam int unsigned FC_ADDR_W  = 2;
    localparam int unsigned FC_NUM_REG = 4;

    typedef enum logic [FC_ADDR_W-1:0] {
        REG_XON_CODE  = 2'd0,
        REG_XOFF_CODE = 2'd1,
        REG_XON_MASK  = 2'd2,
        REG_XOFF_MASK = 2'd3
    } fc_reg_e;

    typedef enum logic {
        FLOW_RUN  = 1'b0,
        FLOW_STOP = 1'b1
    } flow_state_e;
endpackage

// File: rtl/fc_cfg_regs.sv
module fc_cfg_regs
    import fc_pkg::*;
#(
    parameter int unsigned DW       = FC_DATA_W,
    parameter int unsigned AW       = FC_ADDR_W,
    parameter logic [DW-1:0] RST_ON  = 8'h11,
    parameter logic [DW-1:0] RST_OFF = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] on_code,
    output logic [DW-1:0] off_code,
    output logic [DW-1:0] on_mask,
    output logic [DW-1:0] off_mask
);
    localparam int unsigned NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    function automatic logic [DW-1:0] reset_value(input int unsigned idx);
        case (idx)
            int'(REG_XON_CODE):  return RST_ON;
            int'(REG_XOFF_CODE): return RST_OFF;
            default:             return '0;
        endcase
    endfunction

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= reset_value(g);
            end else if (we && (addr == AW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata    = regs[addr];
    assign on_code  = regs[REG_XON_CODE];
    assign off_code = regs[REG_XOFF_CODE];
    assign on_mask  = regs[REG_XON_MASK];
    assign off_mask = regs[REG_XOFF_MASK];
endmodule

// File: rtl/fc_char_match.sv
module fc_char_match
    import fc_pkg::*;
#(
    parameter int unsigned DW      = FC_DATA_W,
    parameter int unsigned LW      = FC_LEN_W,
    parameter int unsigned MIN_LEN = FC_MIN_LEN
) (
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] code,
    input  logic [DW-1:0] mask,
    input  logic [LW-1:0] len_sel,
    output logic          hit
);
    localparam int unsigned CW = $clog2(DW + 1) + 1;

    logic [CW-1:0] width;
    logic [DW-1:0] miss;

    assign width = CW'(MIN_LEN) + CW'(len_sel);

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic in_len;
        assign in_len  = (CW'(b) < width);
        assign miss[b] = in_len & ~mask[b] & (data[b] ^ code[b]);
    end

    assign hit = ~|miss;
endmodule

// File: rtl/fc_flow_fsm.sv
module fc_flow_fsm
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_on,
    input  logic ev_off,
    output logic on_pulse,
    output logic off_pulse,
    output logic hold
);
    flow_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLOW_RUN:  if (ev_off) state_d = FLOW_STOP;
            FLOW_STOP: if (ev_on && !ev_off) state_d = FLOW_RUN;
            default:   state_d = FLOW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLOW_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_pulse  <= 1'b0;
            off_pulse <= 1'b0;
        end else begin
            off_pulse <= ev_off;
            on_pulse  <= ev_on & ~ev_off;
        end
    end

    assign hold = (state_q == FLOW_STOP);
endmodule

// File: rtl/flow_char_detect.sv
module flow_char_detect
    import fc_pkg::*;
#(
    parameter int unsigned DW      = FC_DATA_W,
    parameter int unsigned LW      = FC_LEN_W,
    parameter int unsigned AW      = FC_ADDR_W,
    parameter int unsigned MIN_LEN = FC_MIN_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic [LW-1:0] char_len,
    input  logic          par_en,
    input  logic          discard_en,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_frame_ok,
    input  logic          rx_par_ok,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_data,
    output logic          xon_seen,
    output logic          xoff_seen,
    output logic          tx_hold,
    input  logic          tx_start_req,
    output logic          tx_start_grant
);
    localparam int unsigned NCODE = 2;
    localparam int unsigned IDX_ON  = 0;
    localparam int unsigned IDX_OFF = 1;

    logic [DW-1:0] code_v [NCODE];
    logic [DW-1:0] mask_v [NCODE];
    logic [NCODE-1:0] hit;
    logic char_ok, ev_on, ev_off, is_ctrl;
    logic          fwr_q;
    logic [DW-1:0] fdat_q;

    fc_cfg_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .on_code  (code_v[IDX_ON]),
        .off_code (code_v[IDX_OFF]),
        .on_mask  (mask_v[IDX_ON]),
        .off_mask (mask_v[IDX_OFF])
    );

    for (genvar k = 0; k < NCODE; k++) begin : g_match
        fc_char_match #(.DW(DW), .LW(LW), .MIN_LEN(MIN_LEN)) u_match (
            .data    (rx_data),
            .code    (code_v[k]),
            .mask    (mask_v[k]),
            .len_sel (char_len),
            .hit     (hit[k])
        );
    end

    assign char_ok = rx_valid & rx_frame_ok & (~par_en | rx_par_ok);
    assign ev_on   = char_ok & hit[IDX_ON];
    assign ev_off  = char_ok & hit[IDX_OFF];
    assign is_ctrl = ev_on | ev_off;

    fc_flow_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_on     (ev_on),
        .ev_off    (ev_off),
        .on_pulse  (xon_seen),
        .off_pulse (xoff_seen),
        .hold      (tx_hold)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwr_q  <= 1'b0;
            fdat_q <= '0;
        end else begin
            fwr_q <= rx_valid & ~(discard_en & is_ctrl);
            if (rx_valid) fdat_q <= rx_data;
        end
    end

    assign fifo_wr        = fwr_q;
    assign fifo_data      = fdat_q;
    assign tx_start_grant = tx_start_req & ~tx_hold;
endmodule

// File: rtl/flow_char_detect_chk.sv
module flow_char_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_frame_ok,
    input logic discard_en,
    input logic fifo_wr,
    input logic xon_seen,
    input logic xoff_seen,
    input logic tx_hold,
    input logic tx_start_req,
    input logic tx_start_grant
);
    // R7
    hold_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_seen |-> tx_hold);
    // R7
    clear_after_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xon_seen |-> !tx_hold);
    // R7
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xon_seen && !xoff_seen) |-> $stable(tx_hold));
    // R8
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xon_seen, xoff_seen}));
    // R5
    bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_frame_ok) |=> (!xon_seen && !xoff_seen));
    // R10
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard_en |=> ((xon_seen || xoff_seen) -> !fifo_wr));
    // R11
    grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_grant |-> (tx_start_req && !tx_hold));
endmodule

bind flow_char_detect flow_char_detect_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid       (rx_valid),
    .rx_frame_ok    (rx_frame_ok),
    .discard_en     (discard_en),
    .fifo_wr        (fifo_wr),
    .xon_seen       (xon_seen),
    .xoff_seen      (xoff_seen),
    .tx_hold        (tx_hold),
    .tx_start_req   (tx_start_req),
    .tx_start_grant (tx_start_grant)
);

// File: tb/flow_char_detect_tb.sv
module flow_char_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 1'b0, discard_en = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_frame_ok = 1'b1, rx_par_ok = 1'b1;
    logic       fifo_wr, xon_seen, xoff_seen, tx_hold, tx_start_grant;
    logic [7:0] fifo_data;
    logic       tx_start_req = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flow_char_detect u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .char_len(char_len),
        .par_en(par_en), .discard_en(discard_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_frame_ok(rx_frame_ok), .rx_par_ok(rx_par_ok),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .xon_seen(xon_seen),
        .xoff_seen(xoff_seen), .tx_hold(tx_hold), .tx_start_req(tx_start_req),
        .tx_start_grant(tx_start_grant)
    );

    typedef struct packed {
        logic [1:0] len;
        logic       pe;
        logic       disc;
        logic       fr;
        logic       po;
        logic [7:0] data;
        logic       e_on;
        logic       e_off;
        logic       e_wr;
        logic       e_hold;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h41, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h13, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h13, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 8'h13, 1'b0, 1'b1, 1'b0, 1'b1},
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 8'h41, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h13, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hD1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF3, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF3, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h91, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one character for one rising edge; results checked on the next falling edge
    task automatic send(input vec_t v, input string req);
        @(negedge clk);
        char_len = v.len; par_en = v.pe; discard_en = v.disc;
        rx_frame_ok = v.fr; rx_par_ok = v.po; rx_data = v.data; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        check({req, " on"},   8'(xon_seen),  8'(v.e_on));
        check({req, " off"},  8'(xoff_seen), 8'(v.e_off));
        check({req, " wr"},   8'(fifo_wr),   8'(v.e_wr));
        check({req, " hold"}, 8'(tx_hold),   8'(v.e_hold));
        if (v.e_wr) check({req, " data"}, fifo_data, v.data);
        @(negedge clk);
        check("R9 pulse drop", 8'({xon_seen, xoff_seen}), 8'h00);
    endtask

    function automatic vec_t mk(input logic [7:0] d, input logic eon, input logic eoff, input logic eh);
        return '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, d, eon, eoff, 1'b1, eh};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hold", 8'(tx_hold), 8'h00);
        check("R1 pulses", 8'({xon_seen, xoff_seen}), 8'h00);
        check("R1 fifo_wr", 8'(fifo_wr), 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_addr = 2'd0; #1 check("R1 xon code", cfg_rdata, 8'h11);
        cfg_addr = 2'd1; #1 check("R1 xoff code", cfg_rdata, 8'h13);
        cfg_addr = 2'd2; #1 check("R1 xon mask", cfg_rdata, 8'h00);
        cfg_addr = 2'd3; #1 check("R1 xoff mask", cfg_rdata, 8'h00);

        // R3 R4 R5 R6 R7 R9 R10 table walk
        for (int i = 0; i < NV; i++) send(VECS[i], $sformatf("R7/R10 vec%0d", i));

        // R11 grant follows hold (hold is 1 here)
        tx_start_req = 1'b1; #1 check("R11 held", 8'(tx_start_grant), 8'h00);
        send(mk(8'h11, 1'b1, 1'b0, 1'b0), "R7 resume");
        check("R11 free", 8'(tx_start_grant), 8'h01);
        tx_start_req = 1'b0; #1 check("R11 no req", 8'(tx_start_grant), 8'h00);

        // R2 write and readback
        wr_reg(2'd0, 8'h5A);
        cfg_addr = 2'd0; #1 check("R2 xon code", cfg_rdata, 8'h5A);
        wr_reg(2'd2, 8'h0F);
        cfg_addr = 2'd2; #1 check("R2 xon mask", cfg_rdata, 8'h0F);
        cfg_addr = 2'd1; #1 check("R2 xoff untouched", cfg_rdata, 8'h13);

        // R4 masked low nibble: 0x53 matches 0x5A under mask 0x0F
        send(mk(8'h13, 1'b0, 1'b1, 1'b1), "R4 off");
        send(mk(8'h53, 1'b1, 1'b0, 1'b0), "R4 masked on");
        send(mk(8'h4A, 1'b0, 1'b0, 1'b0), "R4 unmasked miss");

        // R8 both match: pause mask all ones matches anything
        wr_reg(2'd3, 8'hFF);
        send(mk(8'h5A, 1'b0, 1'b1, 1'b1), "R8 both");

        // R1 reset returns to run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 hold after reset", 8'(tx_hold), 8'h00);
        cfg_addr = 2'd3; #1 check("R1 mask after reset", cfg_rdata, 8'h00);
        rst_n = 1'b1;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule